// File: doc/BRIEF.md
# PCI Interrupt Swizzle and Router

This block turns interrupt pin activity from PCI devices into request levels for a 16-input interrupt controller. Each event names a device/function byte, an interrupt pin index (0 to 3 for pins A to D) and a level. The block maps the event onto one of four shared PCI interrupt lines. A few on-board slots have fixed wiring. Four expansion slots use a rotating swizzle. Any other slot passes its pin index through as the line number. The block stores the current level of each line.

Each of the four lines has a routing byte that a configuration write port sets. The byte names the controller input that the line drives. A byte value of 16 or more leaves the line unrouted. Every controller input carries the OR of all stored line levels whose routing bytes select it. As an alternative to single-pin events, the four line levels can also be loaded together in one cycle.

Top module: `pirq_router`

## Requirements
- R1: After reset every routing byte holds 0x80 (unrouted) and every line level is low, so all 16 request outputs are low even if all four lines are later driven high.
- R2: The slot number is the device/function byte shifted right by 3, so the low three function bits do not affect mapping. Slot 10 drives line 3, slot 11 drives line 1 and slot 12 drives line 2, whatever the pin.
- R3: Slots 18 to 21 drive line ((slot - 18) + pin) mod 4.
- R4: Any other slot drives the line whose number equals the pin index.
- R5: The line levels are stored. An event changes only the line it maps to, and the outputs are recomputed from all four stored levels.
- R6: A direct load (`lineLoadValid`) sets all four line levels at once, with bit i giving line i. When a direct load and an event arrive in the same cycle, the direct load wins and the event is dropped.
- R7: A routing write (`cfgWrEn`) replaces the byte of line `cfgWrLine`. A value below 16 routes that line to controller input `cfgWrData`, and any value of 16 or more leaves the line unrouted.
- R8: Controller input k is the OR of the levels of all lines whose routing byte equals k. An input that no routed line selects is low.
- R9: An event, direct load or routing write shows on `ctrlReq` after the next rising clock edge. The outputs do not change in a cycle with none of these.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Single-pin interrupt event strobe |
| evtDevFn | input | 8 | Device/function byte of the event |
| evtPin | input | 2 | Interrupt pin index (0 = A ... 3 = D) |
| evtLevel | input | 1 | New level of that pin |
| lineLoadValid | input | 1 | Load all four line levels at once |
| lineLoadLevels | input | 4 | Levels for the direct load, bit i = line i |
| cfgWrEn | input | 1 | Routing byte write strobe |
| cfgWrLine | input | 2 | Line whose routing byte is written |
| cfgWrData | input | 8 | New routing byte |
| ctrlReq | output | 16 | Request level per controller input |

## Verification
The checker tests on every cycle that no more than four requests are active at once. It checks that the fixed-slot and pass-through events land on the right stored line, and that a direct load wins over an event. It also checks that `ctrlReq` holds steady in any cycle without an event, load or write. The rotating swizzle over all four expansion slots and all pins needs the bench's scenarios. So do the OR merge of two lines onto one input, the disabling effect of routing values 16 and 0xFF, and the reset routing state.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  parameter int LINE_CNT   = 4;
  parameter int LINE_IDX_W = $clog2(LINE_CNT);
  parameter int ROUTE_W    = 8;
  parameter int DEVFN_W    = 8;
  parameter int FUNC_W     = 3;
  parameter int SLOT_W     = DEVFN_W - FUNC_W;
  parameter logic [ROUTE_W-1:0] ROUTE_RESET = 8'h80;

  typedef struct packed {
    logic                  lineWr;
    logic [LINE_IDX_W-1:0] lineIdx;
    logic                  lineLvl;
    logic                  bulkWr;
    logic [LINE_CNT-1:0]   bulkLvl;
    logic                  routeWr;
    logic [LINE_IDX_W-1:0] routeIdx;
    logic [ROUTE_W-1:0]    routeVal;
  } ctrlStrobes_t;
endpackage

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
#(
  parameter int SLOT_A    = 10,
  parameter int SLOT_B    = 11,
  parameter int SLOT_C    = 12,
  parameter int LINE_A    = 3,
  parameter int LINE_B    = 1,
  parameter int LINE_C    = 2,
  parameter int SWZ_BASE  = 18,
  parameter int SWZ_COUNT = 4
) (
  input  logic                  evtValid,
  input  logic [DEVFN_W-1:0]    evtDevFn,
  input  logic [LINE_IDX_W-1:0] evtPin,
  input  logic                  evtLevel,
  input  logic                  lineLoadValid,
  input  logic [LINE_CNT-1:0]   lineLoadLevels,
  input  logic                  cfgWrEn,
  input  logic [LINE_IDX_W-1:0] cfgWrLine,
  input  logic [ROUTE_W-1:0]    cfgWrData,
  output ctrlStrobes_t          strobes
);
  logic [SLOT_W-1:0]     slotNum;
  logic [SLOT_W-1:0]     swzOffset;
  logic [LINE_IDX_W-1:0] mappedLine;

  assign slotNum   = evtDevFn[DEVFN_W-1:FUNC_W];
  assign swzOffset = slotNum - SLOT_W'(SWZ_BASE);

  always_comb begin
    if (slotNum == SLOT_W'(SLOT_A))
      mappedLine = LINE_IDX_W'(LINE_A);
    else if (slotNum == SLOT_W'(SLOT_B))
      mappedLine = LINE_IDX_W'(LINE_B);
    else if (slotNum == SLOT_W'(SLOT_C))
      mappedLine = LINE_IDX_W'(LINE_C);
    else if (slotNum >= SLOT_W'(SWZ_BASE) && slotNum < SLOT_W'(SWZ_BASE + SWZ_COUNT))
      mappedLine = swzOffset[LINE_IDX_W-1:0] + evtPin;
    else
      mappedLine = evtPin;
  end

  always_comb begin
    strobes.bulkWr   = lineLoadValid;
    strobes.bulkLvl  = lineLoadLevels;
    strobes.lineWr   = evtValid && !lineLoadValid;
    strobes.lineIdx  = mappedLine;
    strobes.lineLvl  = evtLevel;
    strobes.routeWr  = cfgWrEn;
    strobes.routeIdx = cfgWrLine;
    strobes.routeVal = cfgWrData;
  end
endmodule

// File: rtl/pirq_dpath.sv
module pirq_dpath
  import pirq_pkg::*;
#(
  parameter int NUM_INPUTS = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  output logic [LINE_CNT-1:0]   lineState,
  output logic [NUM_INPUTS-1:0] ctrlReq
);
  localparam int IN_IDX_W = $clog2(NUM_INPUTS);

  logic [ROUTE_W-1:0]  routeByte [LINE_CNT];
  logic [LINE_CNT-1:0] routeOn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineState <= '0;
    end else if (strobes.bulkWr) begin
      lineState <= strobes.bulkLvl;
    end else if (strobes.lineWr) begin
      lineState[strobes.lineIdx] <= strobes.lineLvl;
    end
  end

  for (genvar l = 0; l < LINE_CNT; l++) begin : g_route
    always_ff @(posedge clk) begin
      if (!rstN)
        routeByte[l] <= ROUTE_RESET;
      else if (strobes.routeWr && strobes.routeIdx == LINE_IDX_W'(l))
        routeByte[l] <= strobes.routeVal;
    end
    assign routeOn[l] = lineState[l] && (routeByte[l] < ROUTE_W'(NUM_INPUTS));
  end

  for (genvar k = 0; k < NUM_INPUTS; k++) begin : g_req
    always_comb begin
      ctrlReq[k] = 1'b0;
      for (int l = 0; l < LINE_CNT; l++) begin
        if (routeOn[l] && routeByte[l][IN_IDX_W-1:0] == IN_IDX_W'(k))
          ctrlReq[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int NUM_INPUTS = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  evtValid,
  input  logic [7:0]            evtDevFn,
  input  logic [1:0]            evtPin,
  input  logic                  evtLevel,
  input  logic                  lineLoadValid,
  input  logic [3:0]            lineLoadLevels,
  input  logic                  cfgWrEn,
  input  logic [1:0]            cfgWrLine,
  input  logic [7:0]            cfgWrData,
  output logic [NUM_INPUTS-1:0] ctrlReq
);
  ctrlStrobes_t        strobes;
  logic [LINE_CNT-1:0] lineState;

  pirq_ctrl u_ctrl (
    .evtValid(evtValid), .evtDevFn(evtDevFn), .evtPin(evtPin), .evtLevel(evtLevel),
    .lineLoadValid(lineLoadValid), .lineLoadLevels(lineLoadLevels),
    .cfgWrEn(cfgWrEn), .cfgWrLine(cfgWrLine), .cfgWrData(cfgWrData),
    .strobes(strobes)
  );

  pirq_dpath #(.NUM_INPUTS(NUM_INPUTS)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .lineState(lineState), .ctrlReq(ctrlReq)
  );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int NUM_INPUTS = 16
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  evtValid,
  input logic [7:0]            evtDevFn,
  input logic [1:0]            evtPin,
  input logic                  evtLevel,
  input logic                  lineLoadValid,
  input logic [3:0]            lineLoadLevels,
  input logic                  cfgWrEn,
  input logic [3:0]            lineState,
  input logic [NUM_INPUTS-1:0] ctrlReq
);
  a_r8_at_most_four: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ctrlReq) <= 4);

  a_r2_slot10_line3: assert property (@(posedge clk) disable iff (!rstN)
    evtValid && !lineLoadValid && evtDevFn[7:3] == 5'd10 |=> lineState[3] == $past(evtLevel));

  a_r4_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    evtValid && !lineLoadValid && evtDevFn[7:3] < 5'd10
      |=> lineState[$past(evtPin)] == $past(evtLevel));

  a_r6_bulk_wins: assert property (@(posedge clk) disable iff (!rstN)
    lineLoadValid |=> lineState == $past(lineLoadLevels));

  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    !evtValid && !lineLoadValid && !cfgWrEn |=> $stable(ctrlReq));
endmodule

bind pirq_router pirq_router_chk #(.NUM_INPUTS(NUM_INPUTS)) u_chk (
  .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtDevFn(evtDevFn),
  .evtPin(evtPin), .evtLevel(evtLevel), .lineLoadValid(lineLoadValid),
  .lineLoadLevels(lineLoadLevels), .cfgWrEn(cfgWrEn),
  .lineState(lineState), .ctrlReq(ctrlReq)
);

// File: tb/sim_pirq_router.sv
`timescale 1ns/1ps
module sim_pirq_router;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evtValid = 1'b0;
  logic [7:0]  evtDevFn = '0;
  logic [1:0]  evtPin = '0;
  logic        evtLevel = 1'b0;
  logic        lineLoadValid = 1'b0;
  logic [3:0]  lineLoadLevels = '0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgWrLine = '0;
  logic [7:0]  cfgWrData = '0;
  logic [15:0] ctrlReq;

  int nRun = 0;
  int nFail = 0;
  logic [3:0] mLvl;
  logic [7:0] mRt [4];

  always #2 clk = ~clk;

  pirq_router u0 (.*);

  function automatic logic [15:0] expOut();
    logic [15:0] r = '0;
    for (int l = 0; l < 4; l++)
      if (mLvl[l] && mRt[l] < 8'd16) r[mRt[l][3:0]] = 1'b1;
    return r;
  endfunction

  function automatic logic [1:0] expLine(input logic [7:0] devFn, input logic [1:0] pin);
    int s = devFn >> 3;
    if (s == 10) return 2'd3;
    if (s == 11) return 2'd1;
    if (s == 12) return 2'd2;
    if (s >= 18 && s <= 21) return 2'((s - 18 + pin) % 4);
    return pin;
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    nRun++;
    if (ctrlReq !== exp) begin
      nFail++;
      $display("FAIL %s: ctrlReq=%h expected=%h", req, ctrlReq, exp);
    end
  endtask

  task automatic doEvt(input logic [7:0] devFn, input logic [1:0] pin, input logic lvl);
    evtValid = 1'b1; evtDevFn = devFn; evtPin = pin; evtLevel = lvl;
    @(negedge clk);
    evtValid = 1'b0;
    mLvl[expLine(devFn, pin)] = lvl;
  endtask

  task automatic doLoad(input logic [3:0] lv);
    lineLoadValid = 1'b1; lineLoadLevels = lv;
    @(negedge clk);
    lineLoadValid = 1'b0;
    mLvl = lv;
  endtask

  task automatic doRoute(input logic [1:0] ln, input logic [7:0] v);
    cfgWrEn = 1'b1; cfgWrLine = ln; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
    mRt[ln] = v;
  endtask

  task automatic tReset();
    check("R1 reset", 16'h0);
    doLoad(4'hF);
    check("R1 unrouted after reset", 16'h0);
  endtask

  task automatic tRouting();
    doRoute(0, 8'd5); doRoute(1, 8'd5); doRoute(2, 8'd9);
    check("R7 partial routes", expOut());
    doRoute(3, 8'd15);
    check("R7 routes 5/9/15", 16'h8220);
    doRoute(3, 8'd16);
    check("R7 value 16 disables", 16'h0220);
    doRoute(3, 8'hFF);
    check("R7 value FF disables", 16'h0220);
    doRoute(3, 8'd15);
    check("R9 route rewrite visible next edge", 16'h8220);
  endtask

  task automatic tFixed();
    doLoad(4'h0);
    check("R6 direct clear", 16'h0);
    doEvt({5'd10, 3'd0}, 2'd0, 1'b1);
    check("R2 slot10 to line3", 16'h8000);
    doEvt({5'd11, 3'd6}, 2'd2, 1'b1);
    check("R2 slot11 to line1 with func bits", 16'h8020);
    doEvt({5'd12, 3'd1}, 2'd3, 1'b1);
    check("R2 slot12 to line2", 16'h8220);
  endtask

  task automatic tOrMerge();
    doLoad(4'h0);
    doEvt({5'd3, 3'd0}, 2'd0, 1'b1);
    doEvt({5'd11, 3'd0}, 2'd0, 1'b1);
    check("R8 two lines on input 5", 16'h0020);
    doEvt({5'd11, 3'd0}, 2'd1, 1'b0);
    check("R5 OR keeps input 5 high", 16'h0020);
    doEvt({5'd3, 3'd0}, 2'd0, 1'b0);
    check("R8 both low", 16'h0000);
  endtask

  task automatic tSwizzle();
    for (int l = 0; l < 4; l++) doRoute(2'(l), 8'(l));
    for (int s = 18; s <= 21; s++) begin
      for (int p = 0; p < 4; p++) begin
        doLoad(4'h0);
        doEvt({5'(s), 3'd2}, 2'(p), 1'b1);
        check("R3 swizzle", 16'(1) << ((s - 18 + p) % 4));
      end
    end
  endtask

  task automatic tPass();
    doLoad(4'h0);
    doEvt({5'd5, 3'd0}, 2'd2, 1'b1);
    check("R4 slot5 pin2 passthrough", 16'h0004);
    doEvt({5'd22, 3'd7}, 2'd1, 1'b1);
    check("R4 slot22 passthrough", 16'h0006);
    doEvt({5'd17, 3'd0}, 2'd3, 1'b1);
    check("R4 slot17 passthrough", 16'h000E);
  endtask

  task automatic tPriority();
    evtValid = 1'b1; evtDevFn = {5'd4, 3'd0}; evtPin = 2'd0; evtLevel = 1'b1;
    lineLoadValid = 1'b1; lineLoadLevels = 4'h8;
    @(negedge clk);
    evtValid = 1'b0; lineLoadValid = 1'b0;
    mLvl = 4'h8;
    check("R6 direct load beats event", 16'h0008);
    @(negedge clk);
    check("R9 idle holds", expOut());
  endtask

  initial begin
    for (int l = 0; l < 4; l++) mRt[l] = 8'h80;
    mLvl = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRouting();
    tFixed();
    tOrMerge();
    tSwizzle();
    tPass();
    tPriority();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule